// File: doc/BRIEF.md
# PPS-Aligned Conversion Timebase

This block derives the sampling timebase for a delta-sigma converter from a 2.048 MHz clock that is itself disciplined to satellite time. A pulse-per-second input is brought into the clock domain. The first such pulse resets the sample-phase divider to zero, which places every logger's sample grid on the same instant. The same pulse also drives a short conversion-start pulse to the converter. After that, the divider runs freely. A later pulse resets it again only when the rearm input is high at that pulse. The plain alignment check then reports when the local phase has slipped away from the pulse.

The divider issues one strobe per sample period. The period is 256 clocks (8 ksps) or 2048 clocks (1 ksps), chosen by `rate_sel`. While the converter's decimation filter settles after a start, strobes still appear but are not marked valid. The settling window defaults to 1160 clocks, which is 0.56640625 ms. Valid strobes are tallied between successive pulses. The tally is latched at each pulse together with a flag that says whether it equals the number expected for one second. The outputs are plain control and status pins: nothing flows with back-pressure, so there is no valid/ready handshake.

Top module: `pps_sample_timer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `adc_start`, `sample_stb`, `sample_valid`, `align_err` and `count_ok` are 0 and `sec_count` is 0.
- R2: `pps_in` passes two synchronising flops. A rising edge first sampled high at clock edge k is acted on at edge k+2 (the "pulse edge"). The first pulse edge after reset re-aligns (jams) the divider to phase 0.
- R3: `adc_start` is high for exactly START_CLKS (default 4) consecutive cycles, beginning in the cycle after a jam edge.
- R4: After a jam, `sample_stb` is a one-cycle pulse in the cycle after every DIV-th edge counted from the jam. DIV is DIV_FAST (256) when `rate_sel`=0 and DIV_SLOW (2048) when `rate_sel`=1. The jam edge itself gives no strobe.
- R5: A strobe issued t edges after the jam raises `sample_valid` together with `sample_stb` only if t-1 >= SETTLE_CLKS (default 1160). Otherwise `sample_valid` stays 0.
- R6: After the first jam, a pulse edge jams again only when `rearm` is 1 at that edge. Otherwise the divider phase and `adc_start` are unaffected.
- R7: At each pulse edge that does not jam, `align_err` is set to 1 if the divider's next phase p satisfies ALIGN_TOL < p < DIV-ALIGN_TOL (default tolerance 2). Otherwise it is set to 0. A jam clears it.
- R8: At every pulse edge, `sec_count` takes the number of valid strobes since the previous pulse edge. A valid strobe visible in that edge's cycle counts toward the following interval. `count_ok` is set to whether that number equals CLK_HZ/DIV.
- R9: Before the first jam, `sample_stb`, `sample_valid` and `adc_start` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz sample-grade clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous pulse-per-second from the time receiver |
| rate_sel | input | 1 | 0 = 8 ksps period, 1 = 1 ksps period |
| rearm | input | 1 | Allow the next pulse to re-align the divider |
| adc_start | output | 1 | Conversion start pulse to the converter |
| sample_stb | output | 1 | One-cycle sample strobe |
| sample_valid | output | 1 | Strobe falls outside the settling window |
| align_err | output | 1 | Divider phase off the pulse by more than the tolerance |
| sec_count | output | CNT_W | Valid strobes counted over the last second |
| count_ok | output | 1 | Last latched count equals the expected count |

## Verification
Two functions share a cycle when a pulse edge coincides with a sample boundary. Perfectly spaced pulses land exactly on the edge that emits a strobe, so the tally must latch the old interval and carry that strobe into the next one. A rearm pulse can also land on a strobe edge, and the jam must then suppress the strobe. Both cases are produced by spacing pulses by exactly one second of clocks, and by adding offsets of +2, +1 and -3 clocks. A behavioural model in the bench tracks elapsed edges and phase and judges every cycle, and explicit checks confirm the first-second and full-second tallies at both rates.

// File: rtl/pps_tmr_pkg.sv
`timescale 1ns/1ps
package pps_tmr_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  function automatic int unsigned period_of(rate_e r, int unsigned fast_div, int unsigned slow_div);
    return (r == RATE_SLOW) ? slow_div : fast_div;
  endfunction

endpackage

// File: rtl/pps_edge_sync.sv
`timescale 1ns/1ps
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/phase_div.sv
`timescale 1ns/1ps
module phase_div
  import pps_tmr_pkg::*;
#(
  parameter int DIV_FAST  = 256,
  parameter int DIV_SLOW  = 2048,
  parameter int ALIGN_TOL = 2,
  localparam int PW = $clog2(DIV_SLOW + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  jam_i,
  input  logic  evt_i,
  input  rate_e rate_i,
  output logic  wrap_o,
  output logic  stb_o,
  output logic  align_err_o
);
  localparam logic [PW-1:0] TOL_V = PW'(ALIGN_TOL);

  logic [PW-1:0] ph;
  logic [PW-1:0] per;
  logic [PW-1:0] np;
  logic          last;

  assign per    = PW'(period_of(rate_i, DIV_FAST, DIV_SLOW));
  assign last   = (ph >= per - PW'(1));
  assign np     = last ? '0 : ph + PW'(1);
  assign wrap_o = run_i & last & ~jam_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= '0;
      stb_o       <= 1'b0;
      align_err_o <= 1'b0;
    end else if (jam_i) begin
      ph          <= '0;
      stb_o       <= 1'b0;
      align_err_o <= 1'b0;
    end else if (run_i) begin
      ph    <= np;
      stb_o <= last;
      if (evt_i) align_err_o <= (np > TOL_V) && (np < per - TOL_V);
    end else begin
      stb_o <= 1'b0;
    end
  end

  AST_PH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph < PW'(DIV_SLOW)); // R4
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o); // R4
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    jam_i |=> !align_err_o); // R7
endmodule

// File: rtl/settle_gate.sv
`timescale 1ns/1ps
module settle_gate #(
  parameter int SETTLE_CLKS = 1160,
  parameter int START_CLKS  = 4,
  localparam int SW = $clog2(SETTLE_CLKS + 1),
  localparam int TW = $clog2(START_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jam_i,
  input  logic wrap_i,
  output logic start_o,
  output logic valid_o
);
  logic [SW-1:0] settle;
  logic [TW-1:0] st_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle  <= '0;
      st_left <= '0;
      valid_o <= 1'b0;
    end else if (jam_i) begin
      settle  <= SW'(SETTLE_CLKS);
      st_left <= TW'(START_CLKS);
      valid_o <= 1'b0;
    end else begin
      if (settle != '0)  settle  <= settle - SW'(1);
      if (st_left != '0) st_left <= st_left - TW'(1);
      valid_o <= wrap_i && (settle == '0);
    end
  end

  assign start_o = (st_left != '0);

  AST_START_AFTER_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    jam_i |=> start_o); // R3
  AST_START_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st_left <= TW'(START_CLKS)); // R3
  AST_NO_VALID_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    (settle > SW'(1)) |=> !valid_o); // R5
endmodule

// File: rtl/sec_tally.sv
`timescale 1ns/1ps
module sec_tally
  import pps_tmr_pkg::*;
#(
  parameter int CLK_HZ   = 2048000,
  parameter int DIV_FAST = 256,
  parameter int DIV_SLOW = 2048,
  parameter int CNT_W    = $clog2(CLK_HZ / DIV_FAST + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             valid_i,
  input  rate_e            rate_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ok_o
);
  localparam int N_FAST = CLK_HZ / DIV_FAST;
  localparam int N_SLOW = CLK_HZ / DIV_SLOW;

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] sum;
  logic [CNT_W-1:0] want;

  assign sum  = run_cnt + CNT_W'(valid_i);
  assign want = (rate_i == RATE_SLOW) ? CNT_W'(N_SLOW) : CNT_W'(N_FAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      count_o <= '0;
      ok_o    <= 1'b0;
    end else if (evt_i) begin
      run_cnt <= '0;
      count_o <= sum;
      ok_o    <= (sum == want);
    end else begin
      run_cnt <= sum;
    end
  end

  AST_TALLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (run_cnt == '0)); // R8
  AST_OK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> $stable(ok_o) && $stable(count_o)); // R8
endmodule

// File: rtl/pps_sample_timer.sv
`timescale 1ns/1ps
module pps_sample_timer
  import pps_tmr_pkg::*;
#(
  parameter int CLK_HZ      = 2048000,
  parameter int DIV_FAST    = 256,
  parameter int DIV_SLOW    = 2048,
  parameter int SETTLE_CLKS = 1160,
  parameter int START_CLKS  = 4,
  parameter int ALIGN_TOL   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(CLK_HZ / DIV_FAST + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_in,
  input  logic             rate_sel,
  input  logic             rearm,
  output logic             adc_start,
  output logic             sample_stb,
  output logic             sample_valid,
  output logic             align_err,
  output logic [CNT_W-1:0] sec_count,
  output logic             count_ok
);
  rate_e rate;
  logic  evt;
  logic  jam;
  logic  armed;
  logic  running;
  logic  wrap;

  assign rate = rate_e'(rate_sel);
  assign jam  = evt & (armed | rearm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b1;
      running <= 1'b0;
    end else if (jam) begin
      armed   <= 1'b0;
      running <= 1'b1;
    end
  end

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pps_in), .rise_o(evt)
  );

  phase_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .ALIGN_TOL(ALIGN_TOL)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(running), .jam_i(jam), .evt_i(evt),
    .rate_i(rate), .wrap_o(wrap), .stb_o(sample_stb), .align_err_o(align_err)
  );

  settle_gate #(.SETTLE_CLKS(SETTLE_CLKS), .START_CLKS(START_CLKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .jam_i(jam), .wrap_i(wrap),
    .start_o(adc_start), .valid_o(sample_valid)
  );

  sec_tally #(.CLK_HZ(CLK_HZ), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .valid_i(sample_valid), .rate_i(rate),
    .count_o(sec_count), .ok_o(count_ok)
  );

  AST_VALID_IS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> sample_stb); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sample_stb && !adc_start); // R9
  AST_NO_REJAM: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !armed && !rearm) |=> !$rose(adc_start)); // R6
  AST_FIRST_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && armed) |=> running && adc_start); // R2
endmodule

// File: tb/pps_sample_timer_bench.sv
`timescale 1ns/1ps
module pps_sample_timer_bench;
  localparam int HZ     = 4096;
  localparam int DF     = 16;
  localparam int DS     = 128;
  localparam int SET    = 72;
  localparam int STL    = 4;
  localparam int TOL    = 2;
  localparam int CW     = $clog2(HZ / DF + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_in = 1'b0;
  logic rate_sel = 1'b0;
  logic rearm = 1'b0;
  logic adc_start, sample_stb, sample_valid, align_err, count_ok;
  logic [CW-1:0] sec_count;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pps_sample_timer #(.CLK_HZ(HZ), .DIV_FAST(DF), .DIV_SLOW(DS), .SETTLE_CLKS(SET),
    .START_CLKS(STL), .ALIGN_TOL(TOL), .CNT_W(CW)) u_pps_sample_timer (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .rate_sel(rate_sel), .rearm(rearm),
    .adc_start(adc_start), .sample_stb(sample_stb), .sample_valid(sample_valid),
    .align_err(align_err), .sec_count(sec_count), .count_ok(count_ok)
  );

  // behavioural reference: elapsed edges since jam, phase, tallies
  int m1, m2, m3, m_armed, m_run, mph, t_el, st_left, vcnt, m_cnt;
  bit m_stb, m_valid, m_err, m_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; m_armed = 1; m_run = 0; mph = 0; t_el = 0;
      st_left = 0; vcnt = 0; m_cnt = 0; m_stb = 0; m_valid = 0; m_err = 0; m_ok = 0;
    end else begin
      bit ev, jm;
      int per;
      ev = (m2 == 1) && (m3 == 0);
      jm = ev && (m_armed == 1 || rearm);
      per = rate_sel ? DS : DF;
      if (ev) begin
        m_cnt = vcnt + (m_valid ? 1 : 0);
        m_ok = (m_cnt == HZ / per);
        vcnt = 0;
      end else begin
        vcnt = vcnt + (m_valid ? 1 : 0);
      end
      if (jm) begin
        mph = 0; t_el = 0; m_stb = 0; m_valid = 0; m_err = 0;
        st_left = STL; m_run = 1; m_armed = 0;
      end else begin
        if (st_left > 0) st_left--;
        if (m_run == 1) begin
          bit w;
          w = (mph >= per - 1);
          mph = w ? 0 : mph + 1;
          t_el++;
          m_stb = w;
          m_valid = w && (t_el - 1 >= SET);
          if (ev) m_err = (mph > TOL) && (mph < per - TOL);
        end else begin
          m_stb = 0; m_valid = 0;
        end
      end
      m3 = m2; m2 = m1; m1 = pps_in;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 adc_start", adc_start, (st_left > 0) ? 1 : 0);
      chk("R4 sample_stb", sample_stb, m_stb);
      chk("R5 sample_valid", sample_valid, m_valid);
      chk("R7 align_err", align_err, m_err);
      chk("R8 sec_count", sec_count, m_cnt);
      chk("R8 count_ok", count_ok, m_ok);
    end
  end

  function automatic int first_sec(int dv);
    int n = 0;
    for (int k = 1; k < HZ / dv; k++) if (k * dv - 1 >= SET) n++;
    return n;
  endfunction

  task automatic send_pps(int lead, bit rr);
    repeat (lead) @(negedge clk);
    pps_in = 1'b1; rearm = rr;
    repeat (10) @(negedge clk);
    pps_in = 1'b0; rearm = 1'b0;
  endtask

  initial begin
    int idle_stb;
    repeat (5) @(negedge clk);
    chk("R1 adc_start", adc_start, 0);
    chk("R1 sample_stb", sample_stb, 0);
    chk("R1 align_err", align_err, 0);
    chk("R1 sec_count", sec_count, 0);
    chk("R1 count_ok", count_ok, 0);
    rst_n = 1'b1;
    idle_stb = 0;
    repeat (200) begin
      @(negedge clk);
      if (sample_stb || adc_start) idle_stb++;
    end
    chk("R9 idle activity", idle_stb, 0);
    // first pulse: jam
    repeat (30) @(negedge clk);
    pps_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 start after first pulse", adc_start, 1);
    repeat (7) @(negedge clk);
    pps_in = 1'b0;
    chk("R2 tally before jam", sec_count, 0);
    send_pps(HZ - 10, 0);
    chk("R5 first second valid count", sec_count, first_sec(DF));
    chk("R8 first second short", count_ok, 0);
    send_pps(HZ - 10, 0);
    chk("R8 full second fast", sec_count, HZ / DF);
    chk("R8 full ok fast", count_ok, 1);
    chk("R7 aligned", align_err, 0);
    send_pps(HZ - 10 + 2, 0);
    chk("R7 offset two tolerated", align_err, 0);
    send_pps(HZ - 10 + 1, 0);
    chk("R7 offset three flagged", align_err, 1);
    chk("R6 no restart without rearm", adc_start, 0);
    repeat (HZ - 10 - 5) @(negedge clk);
    rate_sel = 1'b1;
    repeat (5) @(negedge clk);
    pps_in = 1'b1; rearm = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 rearm restarts", adc_start, 1);
    chk("R7 jam clears error", align_err, 0);
    repeat (6) @(negedge clk);
    pps_in = 1'b0; rearm = 1'b0;
    send_pps(HZ - 10, 0);
    chk("R5 first second slow", sec_count, first_sec(DS));
    send_pps(HZ - 10, 0);
    chk("R4 full second slow", sec_count, HZ / DS);
    chk("R8 full ok slow", count_ok, 1);
    send_pps(HZ - 10 - 3, 0);
    chk("R7 negative offset flagged", align_err, 1);
    repeat (100) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule